// File: doc/BRIEF.md
# Dual-Slot Edge Capture Unit

This block watches one external pin and, on the edges chosen by a two-bit mode field, stores the value of a free-running counter. It has two capture slots. The first qualifying edge fills slot one, and the next qualifying edge fills slot two. After both slots are full, further edges are dropped until the slot pointer is re-armed. The pin is asynchronous to the block clock, so it passes through a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier.

A one-cycle event pulse marks the completion of a capture. A select input chooses whether the pulse follows the first capture or the second capture. Software re-arms the slot pointer in one of two ways: with a clear strobe, which corresponds to acknowledging the capture status, or by switching the mode from off to any active mode. Capture happens only while the pin is configured as an input. The counter itself and any interrupt masking live outside this block.

Top module: `edgecap_dual`

## Requirements
- R1: While `rst_n` is low at a clock edge, both capture registers become zero and `cap_evt_o` becomes low at that edge.
- R2: `cap_mode_i` selects the qualifying edges of the synchronized pin: 0 none, 1 rising only, 2 falling only, 3 both. An edge of a kind that is not selected stores nothing and raises no event.
- R3: While `pin_is_input_i` is 0, edges store nothing and raise no event.
- R4: After re-arm, the first qualifying edge writes `cap_first_o` and the second writes `cap_second_o`. Later edges leave both registers unchanged until the pointer is re-armed.
- R5: `cap_evt_o` is high for exactly one cycle, in the same cycle that a newly written register first shows its value. With `second_sel_i` = 0 the pulse follows the write of the first slot. With `second_sel_i` = 1 it follows the write of the second slot.
- R6: A high `slot_clear_i` at a clock edge returns the pointer to the first slot. An edge detected in that same cycle is dropped.
- R7: A clock edge at which `cap_mode_i` is nonzero, while it was 0 at the previous edge, returns the pointer to the first slot. An edge detected in that cycle is dropped.
- R8: A pin change first sampled at clock edge k is written at edge k+2. The stored value is the `count_i` value presented during the cycle that ends at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | CNT_W | Counter value to be captured |
| pin_i | input | 1 | Asynchronous capture pin |
| cap_mode_i | input | 2 | Edge select: 0 none, 1 rise, 2 fall, 3 both |
| pin_is_input_i | input | 1 | 1 when the pin is configured as an input |
| second_sel_i | input | 1 | 0: event after first capture, 1: event after second |
| slot_clear_i | input | 1 | Strobe that re-arms the slot pointer |
| cap_first_o | output | CNT_W | First capture slot |
| cap_second_o | output | CNT_W | Second capture slot |
| cap_evt_o | output | 1 | One-cycle capture event pulse |

## Verification
Directed pulse trains are run in each edge mode with a fixed pulse shape. Rising-only and falling-only runs use the same waveform, so the results show which edge each mode captures. Both-edge mode fills both slots from a single pulse, which checks that the pointer advances on each edge. The event count in each run shows which slot drives the event pulse.

Separate runs hold the pin as an output, keep the clear strobe high, and park the mode at off and then re-enable it. These show which re-arm or blocking condition is in effect. A long seeded random run mixes pin toggles, mode changes, clears and direction flips with changing counter values. A bench reference model checks the two-edge latency and the value stored on every cycle.

// File: rtl/edgecap_pkg.sv
// Shared definitions for the dual-slot edge capture unit.
// Assumes exactly two capture slots; the slot pointer also encodes "full".
package edgecap_pkg;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_mode_e;

    localparam int NUM_SLOTS = 2;
    localparam int SLOT_W    = $clog2(NUM_SLOTS + 1);

    typedef logic [SLOT_W-1:0] slot_idx_t;

endpackage

// File: rtl/edgecap_sync.sv
// Multi-stage level synchronizer for an asynchronous input.
// Assumes the input is a slow level signal; the output lags by STAGES edges.
module edgecap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                // Later stages shift the sampled level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/edgecap_edge_qual.sv
// Edge detector and qualifier on the synchronized pin.
// Assumes sync_i is already clean; hit_o is combinational for the current cycle.
module edgecap_edge_qual
    import edgecap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_i,
    input  cap_mode_e mode_i,
    input  logic      dir_in_i,
    output logic      hit_o
);

    logic prev_q;
    logic rise;
    logic fall;
    logic sel_edge;

    // Remember the synchronized level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_i;
    end

    assign rise = sync_i & ~prev_q;
    assign fall = ~sync_i & prev_q;

    // Pick the edges the mode asks for.
    always_comb begin
        unique case (mode_i)
            CAP_RISE: sel_edge = rise;
            CAP_FALL: sel_edge = fall;
            CAP_BOTH: sel_edge = rise | fall;
            default:  sel_edge = 1'b0;
        endcase
    end

    assign hit_o = sel_edge & dir_in_i;

endmodule

// File: rtl/edgecap_slot_ctrl.sv
// Slot pointer, re-arm logic and event generation.
// Assumes hit_o from the qualifier; the pointer saturates at NUM_SLOTS (full).
module edgecap_slot_ctrl
    import edgecap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit_i,
    input  logic                 clear_i,
    input  cap_mode_e            mode_i,
    input  logic                 second_sel_i,
    output logic [NUM_SLOTS-1:0] wr_en_o,
    output slot_idx_t            slot_o,
    output logic                 rearm_o,
    output logic                 evt_o
);

    slot_idx_t slot_q;
    cap_mode_e mode_prev_q;
    logic      evt_q;
    logic      take;
    logic      room;

    // Track the mode of the previous cycle for off-to-active detection.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_prev_q <= CAP_OFF;
        else        mode_prev_q <= mode_i;
    end

    assign rearm_o = (mode_prev_q == CAP_OFF) && (mode_i != CAP_OFF);
    assign room    = slot_q < slot_idx_t'(NUM_SLOTS);
    assign take    = hit_i && !clear_i && !rearm_o && room;

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_wr
            assign wr_en_o[i] = take && (slot_q == slot_idx_t'(i));
        end
    endgenerate

    // Advance the pointer on a capture; re-arm wins over a capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                slot_q <= '0;
        else if (clear_i || rearm_o) slot_q <= '0;
        else if (take)             slot_q <= slot_q + slot_idx_t'(1);
    end

    // Raise the event on the capture into the selected slot.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= take && (slot_q == slot_idx_t'(second_sel_i));
    end

    assign slot_o = slot_q;
    assign evt_o  = evt_q;

endmodule

// File: rtl/edgecap_store.sv
// Bank of capture registers, one per slot, written by one-hot enables.
// Assumes at most one enable is high per cycle.
module edgecap_store
    import edgecap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SLOTS-1:0]            wr_en_i,
    input  logic [CNT_W-1:0]                count_i,
    output logic [NUM_SLOTS-1:0][CNT_W-1:0] slots_o
);

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
            // Hold the captured count of this slot.
            always_ff @(posedge clk) begin
                if (!rst_n)         slots_o[i] <= '0;
                else if (wr_en_i[i]) slots_o[i] <= count_i;
            end
        end
    endgenerate

endmodule

// File: rtl/edgecap_dual.sv
// Top of the dual-slot edge capture unit.
// Assumes count_i is synchronous to clk and pin_i is asynchronous.
module edgecap_dual
    import edgecap_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             pin_i,
    input  logic [1:0]       cap_mode_i,
    input  logic             pin_is_input_i,
    input  logic             second_sel_i,
    input  logic             slot_clear_i,
    output logic [CNT_W-1:0] cap_first_o,
    output logic [CNT_W-1:0] cap_second_o,
    output logic             cap_evt_o
);

    cap_mode_e                      mode;
    logic                           pin_sync;
    logic                           hit;
    logic [NUM_SLOTS-1:0]           wr_en;
    slot_idx_t                      slot_idx;
    logic                           rearm;
    logic [NUM_SLOTS-1:0][CNT_W-1:0] slots;

    assign mode = cap_mode_e'(cap_mode_i);

    edgecap_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    edgecap_edge_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (pin_sync),
        .mode_i   (mode),
        .dir_in_i (pin_is_input_i),
        .hit_o    (hit)
    );

    edgecap_slot_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit),
        .clear_i      (slot_clear_i),
        .mode_i       (mode),
        .second_sel_i (second_sel_i),
        .wr_en_o      (wr_en),
        .slot_o       (slot_idx),
        .rearm_o      (rearm),
        .evt_o        (cap_evt_o)
    );

    edgecap_store #(.CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .count_i (count_i),
        .slots_o (slots)
    );

    assign cap_first_o  = slots[0];
    assign cap_second_o = slots[1];

endmodule

// File: rtl/edgecap_dual_chk.sv
// Assertion checker for edgecap_dual, attached by bind.
module edgecap_dual_chk
    import edgecap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_clear_i,
    input logic             pin_is_input_i,
    input slot_idx_t        slot_idx,
    input logic             rearm,
    input logic [CNT_W-1:0] cap_first_o,
    input logic [CNT_W-1:0] cap_second_o,
    input logic             cap_evt_o
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (cap_first_o == '0 && cap_second_o == '0 && !cap_evt_o));

    assert_no_capture_as_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_is_input_i |=> ($stable(cap_first_o) && $stable(cap_second_o) && !cap_evt_o));

    assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == slot_idx_t'(NUM_SLOTS)) |=> ($stable(cap_first_o) && $stable(cap_second_o)));

    assert_slot_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= slot_idx_t'(NUM_SLOTS));

    assert_evt_with_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_o |-> (slot_idx == $past(slot_idx) + slot_idx_t'(1)));

    assert_clear_rearms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_clear_i |=> (slot_idx == '0 && !cap_evt_o));

    assert_mode_rearms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (slot_idx == '0 && !cap_evt_o));

endmodule

bind edgecap_dual edgecap_dual_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_clear_i   (slot_clear_i),
    .pin_is_input_i (pin_is_input_i),
    .slot_idx       (slot_idx),
    .rearm          (rearm),
    .cap_first_o    (cap_first_o),
    .cap_second_o   (cap_second_o),
    .cap_evt_o      (cap_evt_o)
);

// File: tb/edgecap_dual_bench.sv
`timescale 1ns/1ps
module edgecap_dual_bench;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] count_i = '0;
    logic         pin_i = 1'b0;
    logic [1:0]   cap_mode_i = 2'd0;
    logic         pin_is_input_i = 1'b1;
    logic         second_sel_i = 1'b0;
    logic         slot_clear_i = 1'b0;
    logic [W-1:0] cap_first_o;
    logic [W-1:0] cap_second_o;
    logic         cap_evt_o;

    int    n_chk = 0;
    int    n_fail = 0;
    int    evt_seen = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model state, built from the requirements.
    logic         m_s1 = 0, m_s2 = 0, m_prev = 0;
    logic [1:0]   m_pmode = 0;
    int           m_slot = 0;
    logic [W-1:0] m_a = 0, m_b = 0;
    logic         m_evt = 0;

    always #4 clk = ~clk;

    edgecap_dual #(.CNT_W(W)) u_edgecap_dual (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .pin_i(pin_i),
        .cap_mode_i(cap_mode_i), .pin_is_input_i(pin_is_input_i),
        .second_sel_i(second_sel_i), .slot_clear_i(slot_clear_i),
        .cap_first_o(cap_first_o), .cap_second_o(cap_second_o),
        .cap_evt_o(cap_evt_o)
    );

    function automatic bit edge_hit(input logic [1:0] md, input logic cur, input logic old);
        case (md)
            2'd1:    return cur && !old;
            2'd2:    return !cur && old;
            2'd3:    return cur != old;
            default: return 0;
        endcase
    endfunction

    // Model update on each clock edge.
    always @(posedge clk) begin
        bit rearm, take;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_pmode = 0;
            m_slot = 0; m_a = 0; m_b = 0; m_evt = 0;
        end else begin
            rearm = (m_pmode == 2'd0) && (cap_mode_i != 2'd0);
            take = edge_hit(cap_mode_i, m_s2, m_prev) && pin_is_input_i
                   && !slot_clear_i && !rearm && (m_slot < 2);
            m_evt = take && (m_slot == int'(second_sel_i));
            if (take) begin
                if (m_slot == 0) m_a = count_i;
                else             m_b = count_i;
            end
            if (slot_clear_i || rearm) m_slot = 0;
            else if (take)             m_slot = m_slot + 1;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_i;
            m_pmode = cap_mode_i;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(cap_first_o == m_a, cur_req, "first slot", cap_first_o, m_a);
            chk(cap_second_o == m_b, cur_req, "second slot", cap_second_o, m_b);
            chk(cap_evt_o == m_evt, cur_req, "event", {31'b0, cap_evt_o}, {31'b0, m_evt});
            if (cap_evt_o) evt_seen++;
            count_i = count_i + 3;
        end
    endtask

    task automatic pulse(input int hi, input int lo);
        pin_i = 1'b1; tick(hi);
        pin_i = 1'b0; tick(lo);
    endtask

    task automatic do_clear();
        slot_clear_i = 1'b1; tick(1);
        slot_clear_i = 1'b0;
    endtask

    initial begin
        logic [W-1:0] c0, sa, sb;
        void'($urandom(32'h5eed_0042));
        count_i = 32'h100;

        // R1: reset state.
        cur_req = "R1";
        tick(3);
        chk(cap_first_o == 0 && cap_second_o == 0, "R1", "regs zero in reset",
            cap_first_o | cap_second_o, 0);
        chk(!cap_evt_o, "R1", "event low in reset", {31'b0, cap_evt_o}, 0);
        rst_n = 1'b1;
        tick(2);

        // R2/R4/R5: rising mode, event on first capture, third edge ignored.
        cur_req = "R4";
        cap_mode_i = 2'd1; second_sel_i = 1'b0; tick(2);
        evt_seen = 0;
        pulse(4, 4); pulse(4, 4);
        sa = cap_first_o; sb = cap_second_o;
        pulse(4, 4);
        chk(evt_seen == 1, "R5", "events with first-slot select", evt_seen, 1);
        chk(cap_first_o == sa && cap_second_o == sb, "R4", "full slots unchanged",
            cap_second_o, sb);

        // R6 + R5: clear, event on second capture.
        cur_req = "R6";
        do_clear();
        second_sel_i = 1'b1; evt_seen = 0;
        pulse(4, 4);
        chk(evt_seen == 0, "R5", "no event after first with second select", evt_seen, 0);
        pulse(4, 4);
        chk(evt_seen == 1, "R5", "event after second capture", evt_seen, 1);

        // R2: falling mode ignores rising edges.
        cur_req = "R2";
        cap_mode_i = 2'd2; do_clear();
        sa = cap_first_o;
        pin_i = 1'b1; tick(5);
        chk(cap_first_o == sa, "R2", "rising edge ignored in falling mode", cap_first_o, sa);
        pin_i = 1'b0; tick(5);
        chk(cap_first_o != sa, "R2", "falling edge captured", cap_first_o, sa);

        // R8 + R2: both mode, latency of two edges.
        cur_req = "R8";
        cap_mode_i = 2'd3; second_sel_i = 1'b0; do_clear(); tick(2);
        evt_seen = 0;
        pin_i = 1'b1; c0 = count_i;
        tick(2);
        chk(cap_evt_o == 1'b0, "R8", "no event before edge k+2", {31'b0, cap_evt_o}, 0);
        tick(1);
        chk(cap_first_o == c0 + 6, "R8", "value from cycle before edge k+2",
            cap_first_o, c0 + 6);
        chk(cap_evt_o == 1'b1, "R8", "event at edge k+2", {31'b0, cap_evt_o}, 1);
        pin_i = 1'b0; tick(5);
        chk(cap_second_o != cap_first_o, "R2", "both mode fills second slot on fall",
            cap_second_o, cap_first_o);

        // R3: pin as output, nothing captured.
        cur_req = "R3";
        do_clear(); pin_is_input_i = 1'b0; evt_seen = 0;
        sa = cap_first_o; sb = cap_second_o;
        pulse(4, 4); pulse(4, 4);
        chk(evt_seen == 0, "R3", "no event as output", evt_seen, 0);
        chk(cap_first_o == sa && cap_second_o == sb, "R3", "regs unchanged as output",
            cap_first_o, sa);

        // R7: off then active re-arms a full pointer.
        cur_req = "R7";
        pin_is_input_i = 1'b1;
        pulse(4, 4);
        cap_mode_i = 2'd0; tick(2);
        cap_mode_i = 2'd3; tick(2);
        evt_seen = 0; sa = cap_first_o;
        pulse(4, 4);
        chk(evt_seen == 1, "R7", "capture after mode re-arm", evt_seen, 1);
        chk(cap_first_o != sa, "R7", "first slot rewritten", cap_first_o, sa);

        // R6: clear held through an edge drops it.
        cur_req = "R6";
        evt_seen = 0; slot_clear_i = 1'b1;
        pulse(4, 4);
        slot_clear_i = 1'b0;
        chk(evt_seen == 0, "R6", "edge dropped under clear", evt_seen, 0);

        // R8: seeded random mix against the model.
        cur_req = "R8";
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 4 == 0) pin_i = ~pin_i;
            if ($urandom % 50 == 0) cap_mode_i = 2'($urandom);
            if ($urandom % 30 == 0) second_sel_i = ~second_sel_i;
            pin_is_input_i = ($urandom % 10) != 0;
            slot_clear_i   = ($urandom % 20) == 0;
            count_i = $urandom;
            tick(1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule